// File: doc/BRIEF.md
# Bit-Serial Montgomery Multiplier

This block forms the Montgomery product of two operands, `x * y * 2^-n mod m`, where `n` is the width of the active lane. It consumes one bit of `x` per iteration. Each iteration takes two clock cycles on a single shared adder: the first cycle adds `y` when the current bit of `x` is set, and the second cycle adds `m` when the partial sum is odd and then halves it. The adder is built as a chain of equal slices with a rippling carry. After the last iteration one conditional subtraction brings the result below `m`.

The datapath is `N` bits wide and is divided into `S` slices. A two-bit lane select runs the multiplier on the whole width, on only the lower `SL` slices, or on only the remaining upper slices. A short operand is therefore placed in its own lane of the wide ports. The caller provides the operands and an odd modulus, pulses `start` for one cycle, and waits for the `ready` level. The block produces no handshake until the fixed latency has passed.

Top module: `mont_mul`

## Requirements
- R1: With lane select 11 (full), `result` equals `op_x * op_y * 2^-N mod op_m` for an odd `op_m`, with `op_x` below 2^N and `op_y` below `op_m`.
- R2: `ready` goes high exactly `S + 2*(n-1)` clock edges after the edge that accepts `start`, where `n` is the lane width (N, NL or NU). It stays low on every edge in between.
- R3: Lane select 01 (lower) uses operand bits `[NL-1:0]` with `NL = (N/S)*SL`, and returns `x*y*2^-NL mod m` in `result[NL-1:0]`.
- R4: Lane select 10 (upper) uses operand bits `[N-1:NL]`, with width `NU = N - NL`, and returns `x*y*2^-NU mod m` in `result[N-1:NL]`.
- R5: In the lower and upper lanes, operand bits outside the lane have no effect, and result bits outside the lane read as zero.
- R6: Once high, `ready` stays high and `result` holds its value until the next accepted `start`. `ready` drops on the edge that accepts that start.
- R7: A `start` pulse that arrives while a product is in progress is ignored. The running product keeps its operands and its timing.
- R8: After reset, `ready` is low and `result` is zero.
- R9: Multiplying `x` by `2^(2n) mod m` returns `x*2^n mod m`, and multiplying that value by 1 returns `x`.
- R10: For inputs below `m` the result is always below `m`, including the case `x = y = m-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a product when idle |
| part_sel | input | 2 | Lane select: 11 full, 01 lower, 10 upper |
| op_x | input | N | Multiplier operand, placed in its lane |
| op_y | input | N | Multiplicand operand, placed in its lane |
| op_m | input | N | Odd modulus, placed in its lane |
| ready | output | 1 | High while a finished result is held |
| result | output | N | Reduced Montgomery product, placed in its lane |

## Verification
On every cycle, the bound checker tracks how `ready` is timed against its own count of edges since the accepted start. It also checks that `ready` and `result` are held, that result bits outside a short lane stay zero, and the state after reset. The arithmetic cannot be expressed as a property: correct products in every lane, the domain round trip, the final subtraction at `m-1`, and the rejection of a start while busy are shown only by the bench. The bench compares these against an independent big-integer model of modular multiplication.

// File: rtl/mont_pkg.sv
package mont_pkg;

    typedef enum logic [1:0] {
        PART_NONE = 2'b00,
        PART_LOW  = 2'b01,
        PART_HIGH = 2'b10,
        PART_FULL = 2'b11
    } part_e;

endpackage

// File: rtl/mont_slice.sv
module mont_slice #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    assign sum  = wide[W-1:0];
    assign cout = wide[W];
endmodule

// File: rtl/mont_seq.sv
module mont_seq
    import mont_pkg::*;
#(
    parameter int N  = 64,
    parameter int S  = 4,
    parameter int SL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] part_sel,
    output logic       load,
    output logic       ph_add_x,
    output logic       ph_add_m,
    output logic       do_sub,
    output logic       ready,
    output logic [1:0] sel_q
);
    localparam int W  = N / S;
    localparam int NL = W * SL;
    localparam int NU = N - NL;
    localparam int CW = $clog2(S + 2 * N + 1);

    typedef struct packed {
        logic          busy;
        logic          rdy;
        logic [CW-1:0] cnt;
        logic [1:0]    sel;
    } seq_t;

    seq_t q, d;
    logic [CW-1:0] width_q;
    logic [CW-1:0] last_q;
    logic          stepping;

    function automatic logic [CW-1:0] lane_width(input logic [1:0] s);
        case (s)
            PART_LOW:  return CW'(NL);
            PART_HIGH: return CW'(NU);
            default:   return CW'(N);
        endcase
    endfunction

    always_comb begin
        width_q  = lane_width(q.sel);
        last_q   = CW'(S - 3) + (width_q << 1);
        stepping = q.busy && (q.cnt < (width_q << 1));
        load     = start && !q.busy;
        ph_add_x = stepping && !q.cnt[0];
        ph_add_m = stepping &&  q.cnt[0];
        do_sub   = q.busy && (q.cnt == (width_q << 1));

        d = q;
        if (load) begin
            d.busy = 1'b1;
            d.rdy  = 1'b0;
            d.cnt  = '0;
            d.sel  = part_sel;
        end else if (q.busy) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == last_q) begin
                d.busy = 1'b0;
                d.rdy  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready = q.rdy;
    assign sel_q = q.sel;
endmodule

// File: rtl/mont_mul.sv
module mont_mul
    import mont_pkg::*;
#(
    parameter int N  = 64,
    parameter int S  = 4,
    parameter int SL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   part_sel,
    input  logic [N-1:0] op_x,
    input  logic [N-1:0] op_y,
    input  logic [N-1:0] op_m,
    output logic         ready,
    output logic [N-1:0] result
);
    localparam int W  = N / S;
    localparam int NL = W * SL;
    localparam int AW = N + 2;
    localparam logic [N-1:0] LOW_MASK = {{(N-NL){1'b0}}, {NL{1'b1}}};

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [N-1:0]  xs;
        logic [N-1:0]  y;
        logic [N-1:0]  m;
        logic [N-1:0]  res;
    } dp_t;

    dp_t q, d;

    logic       load, ph_add_x, ph_add_m, do_sub;
    logic [1:0] sel_q;

    logic [N-1:0]  b_vec;
    logic [N-1:0]  sum_lo;
    logic [S:0]    carry;
    logic [AW-1:0] sum_full;
    logic [AW-1:0] diff;
    logic [N-1:0]  reduced;

    mont_seq #(.N(N), .S(S), .SL(SL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .part_sel (part_sel),
        .load     (load),
        .ph_add_x (ph_add_x),
        .ph_add_m (ph_add_m),
        .do_sub   (do_sub),
        .ready    (ready),
        .sel_q    (sel_q)
    );

    // Slice chain: carry ripples from the lowest slice upward each cycle.
    assign carry[0] = 1'b0;
    for (genvar s = 0; s < S; s++) begin : g_slice
        mont_slice #(.W(W)) u_slice (
            .a    (q.acc[s*W +: W]),
            .b    (b_vec[s*W +: W]),
            .cin  (carry[s]),
            .sum  (sum_lo[s*W +: W]),
            .cout (carry[s+1])
        );
    end

    function automatic logic [N-1:0] lane_in(input logic [N-1:0] v, input logic [1:0] s);
        case (s)
            PART_LOW:  return v & LOW_MASK;
            PART_HIGH: return v >> NL;
            default:   return v;
        endcase
    endfunction

    function automatic logic [N-1:0] lane_out(input logic [N-1:0] v, input logic [1:0] s);
        case (s)
            PART_LOW:  return v & LOW_MASK;
            PART_HIGH: return v << NL;
            default:   return v;
        endcase
    endfunction

    always_comb begin
        b_vec = '0;
        if (ph_add_x && q.xs[0])  b_vec = q.y;
        if (ph_add_m && q.acc[0]) b_vec = q.m;

        sum_full = {q.acc[AW-1:N] + {1'b0, carry[S]}, sum_lo};
        diff     = q.acc - {2'b00, q.m};
        reduced  = (q.acc >= {2'b00, q.m}) ? diff[N-1:0] : q.acc[N-1:0];

        d = q;
        if (load) begin
            d.acc = '0;
            d.xs  = lane_in(op_x, part_sel);
            d.y   = lane_in(op_y, part_sel);
            d.m   = lane_in(op_m, part_sel);
        end
        if (ph_add_x) begin
            d.acc = sum_full;
        end
        if (ph_add_m) begin
            d.acc = sum_full >> 1;
            d.xs  = q.xs >> 1;
        end
        if (do_sub) begin
            d.res = lane_out(reduced, sel_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result = q.res;
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk
    import mont_pkg::*;
#(
    parameter int N  = 64,
    parameter int S  = 4,
    parameter int SL = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   part_sel,
    input logic         ready,
    input logic [N-1:0] result
);
    localparam int W  = N / S;
    localparam int NL = W * SL;
    localparam int NU = N - NL;
    localparam int CW = $clog2(S + 2 * N + 1);

    logic          c_busy;
    logic [CW-1:0] c_cnt;
    logic [CW-1:0] c_lat;
    logic [1:0]    c_sel;
    logic          c_take;
    logic [CW-1:0] lat_new;

    always_comb begin
        case (part_sel)
            PART_LOW:  lat_new = CW'(S + 2 * NL - 2);
            PART_HIGH: lat_new = CW'(S + 2 * NU - 2);
            default:   lat_new = CW'(S + 2 * N - 2);
        endcase
        c_take = start && (!c_busy || (c_cnt == c_lat));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_busy <= 1'b0;
            c_cnt  <= '0;
            c_lat  <= '0;
            c_sel  <= PART_FULL;
        end else if (c_take) begin
            c_busy <= 1'b1;
            c_cnt  <= '0;
            c_lat  <= lat_new;
            c_sel  <= part_sel;
        end else if (c_busy) begin
            if (c_cnt == c_lat) c_busy <= 1'b0;
            else                c_cnt  <= c_cnt + 1'b1;
        end
    end

    // R2: ready is high exactly when the edge count reaches the latency
    p_ready_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_busy |-> (ready == (c_cnt == c_lat)));

    // R6: ready level holds while no new start arrives
    p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready);

    // R6: result is held while ready and no new start
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> $stable(result));

    // R5: bits above the lower lane are zero
    p_low_lane_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && c_sel == PART_LOW) |-> (result[N-1:NL] == '0));

    // R5: bits below the upper lane are zero
    p_high_lane_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && c_sel == PART_HIGH) |-> (result[NL-1:0] == '0));

    // R8: reset clears the outputs
    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (!ready && result == '0));
endmodule

bind mont_mul mont_mul_chk #(.N(N), .S(S), .SL(SL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .part_sel (part_sel),
    .ready    (ready),
    .result   (result)
);

// File: tb/mont_mul_test.sv
module mont_mul_test;
    localparam int N  = 64;
    localparam int S  = 4;
    localparam int SL = 1;
    localparam int NL = (N / S) * SL;
    localparam int NU = N - NL;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   part_sel = 2'b11;
    logic [N-1:0] op_x = '0, op_y = '0, op_m = '0;
    logic         ready;
    logic [N-1:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mont_mul #(.N(N), .S(S), .SL(SL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .part_sel(part_sel),
        .op_x(op_x), .op_y(op_y), .op_m(op_m), .ready(ready), .result(result)
    );

    function automatic logic [127:0] mulmod(input logic [127:0] a, b, m);
        return (a * b) % m;
    endfunction

    // Independent model: x*y*(2^-n) mod m using the inverse of 2 modulo m.
    function automatic logic [127:0] model(input logic [127:0] x, y, m, input int n);
        logic [127:0] inv2, rinv;
        inv2 = (m + 1) >> 1;
        rinv = 1;
        for (int i = 0; i < n; i++) rinv = mulmod(rinv, inv2, m);
        return mulmod(mulmod(x % m, y, m), rinv, m);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_mul(input logic [1:0] sel, input logic [N-1:0] x, y, m,
                           output logic [N-1:0] res, output int lat);
        @(negedge clk);
        part_sel = sel; op_x = x; op_y = y; op_m = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int k = 1; k < 1000; k++) begin
            @(posedge clk); #1;
            if (ready) begin lat = k; break; end
        end
        res = result;
    endtask

    task automatic t_reset();
        check(ready == 1'b0, "R8 ready after reset", 128'(ready), 0);
        check(result == '0, "R8 result after reset", 128'(result), 0);
    endtask

    task automatic t_full(input logic [N-1:0] x, y, m);
        logic [N-1:0] r; int lat; logic [127:0] e;
        run_mul(2'b11, x, y, m, r, lat);
        e = model(x, y, m, N);
        check(128'(r) == e, "R1 full product", 128'(r), e);
        check(lat == S + 2 * (N - 1), "R2 full latency", 128'(lat), 128'(S + 2 * (N - 1)));
    endtask

    task automatic t_range();
        logic [N-1:0] m, r; int lat; logic [127:0] e;
        m = 64'hFFFF_FFFF_FFFF_FFC5;
        run_mul(2'b11, m - 1, m - 1, m, r, lat);
        e = model(m - 1, m - 1, m, N);
        check(128'(r) == e, "R10 product at m-1", 128'(r), e);
        check(r < m, "R10 result below m", 128'(r), 128'(m));
    endtask

    task automatic t_lower();
        logic [15:0] m, x, y; logic [N-1:0] r; int lat; logic [127:0] e;
        m = 16'hF00D; x = 16'h1234; y = 16'hABCD;
        run_mul(2'b01, {48'hDEAD_BEEF_5A5A, x}, {48'h1357_9BDF_0246, y},
                {48'hFFFF_0000_FFFF, m}, r, lat);
        e = model(x, y, m, NL);
        check(128'(r[NL-1:0]) == e, "R3 lower product", 128'(r[NL-1:0]), e);
        check(lat == S + 2 * (NL - 1), "R2 lower latency", 128'(lat), 128'(S + 2 * (NL - 1)));
        check(r[N-1:NL] == '0, "R5 lower outside lane zero", 128'(r), e);
    endtask

    task automatic t_upper();
        logic [47:0] m, x, y; logic [N-1:0] r; int lat; logic [127:0] e;
        m = 48'hC0FF_EE12_3457; x = 48'h1111_2222_3333; y = 48'h0ABC_DEF0_1235;
        run_mul(2'b10, {x, 16'hBEEF}, {y, 16'h7777}, {m, 16'hFFFF}, r, lat);
        e = model(x, y, m, NU);
        check(128'(r[N-1:NL]) == e, "R4 upper product", 128'(r[N-1:NL]), e);
        check(lat == S + 2 * (NU - 1), "R2 upper latency", 128'(lat), 128'(S + 2 * (NU - 1)));
        check(r[NL-1:0] == '0, "R5 upper outside lane zero", 128'(r), e);
    endtask

    task automatic t_domain();
        logic [N-1:0] m, x, r2, a, back; int lat; logic [127:0] rr;
        m = 64'hE3A1_5C27_9B40_6D15; x = 64'h0123_4567_89AB_CDEF;
        rr = (128'h1 << N) % m;
        r2 = N'(mulmod(rr, rr, m));
        run_mul(2'b11, x, r2, m, a, lat);
        check(128'(a) == mulmod(x, rr, m), "R9 into domain", 128'(a), mulmod(x, rr, m));
        run_mul(2'b11, a, 64'd1, m, back, lat);
        check(back == x, "R9 out of domain", 128'(back), 128'(x));
    endtask

    task automatic t_hold_and_busy();
        logic [N-1:0] m, x, y, x2, r0; int lat; logic [127:0] e;
        m = 64'hE3A1_5C27_9B40_6D15; x = 64'h1234_5678_9ABC_DEF0; y = 64'h0FED_CBA9_8765_4321;
        x2 = 64'h0000_0000_0000_0005;
        run_mul(2'b11, x, y, m, r0, lat);
        repeat (20) @(posedge clk);
        #1;
        check(ready == 1'b1, "R6 ready held", 128'(ready), 1);
        check(result == r0, "R6 result held", 128'(result), 128'(r0));
        // New start: ready must drop at the accepting edge
        @(negedge clk);
        op_x = x; op_y = y; op_m = m; part_sel = 2'b11; start = 1'b1;
        @(posedge clk); #1;
        check(ready == 1'b0, "R6 ready drops on new start", 128'(ready), 0);
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        // Start while busy with other operands: must be ignored
        op_x = x2; op_y = x2; part_sel = 2'b01; start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        for (int k = 12; k < 1000; k++) begin
            @(posedge clk); #1;
            if (ready) begin lat = k; break; end
        end
        e = model(x, y, m, N);
        check(128'(result) == e, "R7 busy start ignored result", 128'(result), e);
        check(lat == S + 2 * (N - 1), "R7 busy start ignored latency", 128'(lat), 128'(S + 2 * (N - 1)));
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_full(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hE3A1_5C27_9B40_6D15);
        t_full(64'hFFFF_FFFF_0000_0001, 64'h8000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFC5);
        t_full(64'h0, 64'h7654_3210_FEDC_BA98, 64'hE3A1_5C27_9B40_6D15);
        t_range();
        t_lower();
        t_upper();
        t_domain();
        t_hold_and_busy();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule